// File: doc/BRIEF.md
# Priority Interrupt Request Controller

This block gathers eight device interrupt request lines and presents them to a processor as one interrupt signal. Each line's rising edge is latched into a pending-request register. The controller picks the highest-priority pending line that is not masked and raises its interrupt output. Line 0 is the most urgent and line 7 the least. When the processor acknowledges, the controller moves the winner from pending to in-service and presents an 8-bit interrupt number. That number is a fixed base plus the line index.

Dispatch never preempts. While any line is in service, no further interrupt is raised, whatever the priority of the waiting requests. Software must write an end-of-interrupt command before the next request is forwarded. A two-address register port lets software set the mask, issue the end-of-interrupt command, and read back the pending, in-service and mask registers.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending and in-service registers read 0x00, the mask reads 0x00, and `int_o` is low.
- R2: A rising edge on `irq_i[n]` sets pending bit n one clock later. A line held high records exactly one request. Bit n of a readback word is line n.
- R3: With no line in service, `int_o` rises one clock after an unmasked request becomes pending.
- R4: Among unmasked pending requests, the lowest line index wins.
- R5: A clock with `inta_i` high while `int_o` is high counts as an acknowledge. After it, `vec_o` reads 0x08 plus the winning line index, for example 0x09 for line 1 and 0x0C for line 4. In that same clock the winner's pending bit clears, its in-service bit sets, and `int_o` falls.
- R6: While any in-service bit is set, `int_o` stays low, even for requests of higher priority than the one in service.
- R7: Writing 0x20 to address 0 clears the in-service bit. Any other value written to address 0 leaves the in-service register unchanged.
- R8: Mask bit n, written and read at address 1, blocks line n from dispatch. The request is still recorded as pending and is dispatched after the bit is cleared.
- R9: A read at address 0 returns the in-service register when `rd_isr_i` is high, and the pending register when it is low.
- R10: After an end-of-interrupt command, or after a mask change that unblocks a pending request, `int_o` rises within two clocks of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Device request lines, index = line number |
| inta_i | input | 1 | Processor acknowledge |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Interrupt number of the last acknowledged line |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = command / status, 1 = mask |
| reg_wdata_i | input | 8 | Write data |
| rd_isr_i | input | 1 | Address-0 readback select: 1 = in-service, 0 = pending |
| reg_rdata_o | output | 8 | Read data |

## Verification
The bench builds the block with its defaults: eight lines, vector base 0x08, and end-of-interrupt code 0x20. With only eight lines, every line can be swept one at a time. The bench also runs the full eight-way contention case, where all lines are pending and are served one by one in priority order, so each vector number is computed as base plus index. Masking, holding a line high, preemption attempts and non-EOI command writes are each tried against this small configuration, and each result is checked at the cycle it is due.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int unsigned REG_ADDR_CMD  = 0;
    localparam int unsigned REG_ADDR_MASK = 1;
    localparam logic [7:0]  EOI_CMD_CODE  = 8'h20;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] prev_i,
    output logic [N-1:0] rise_o
);
    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise_o[g] = line_i[g] & ~prev_i[g];
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N  = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    logic [N:0] lower;
    assign lower[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign lower[g+1]  = lower[g] | req_i[g];
        assign grant_o[g]  = req_i[g] & ~lower[g];
    end

    assign any_o = lower[N];

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int unsigned N        = 8,
    parameter int unsigned DW       = 8,
    parameter logic [7:0]  VEC_BASE = 8'h08
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_i,
    input  logic          inta_i,
    output logic          int_o,
    output logic [DW-1:0] vec_o,
    input  logic          reg_we_i,
    input  logic          reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    input  logic          rd_isr_i,
    output logic [DW-1:0] reg_rdata_o
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]  irr;
        logic [N-1:0]  isr;
        logic [N-1:0]  mask;
        logic [N-1:0]  prev;
        logic          intr;
        logic [DW-1:0] vec;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [N-1:0]  rise;
    logic [N-1:0]  pend_unmasked;
    logic [N-1:0]  win_onehot;
    logic [IW-1:0] win_idx;
    logic          win_any;
    logic [N-1:0]  isr_low;
    logic [IW-1:0] isr_idx_unused;
    logic          isr_any_unused;
    logic          ack;
    logic          eoi;
    logic          mask_wr;

    irq_edge_capture #(.N(N)) u_edge (
        .line_i (irq_i),
        .prev_i (st_q.prev),
        .rise_o (rise)
    );

    assign pend_unmasked = st_q.irr & ~st_q.mask;

    irq_prio_pick #(.N(N)) u_pick (
        .req_i   (pend_unmasked),
        .grant_o (win_onehot),
        .idx_o   (win_idx),
        .any_o   (win_any)
    );

    irq_prio_pick #(.N(N)) u_isr_pick (
        .req_i   (st_q.isr),
        .grant_o (isr_low),
        .idx_o   (isr_idx_unused),
        .any_o   (isr_any_unused)
    );

    assign ack     = inta_i & st_q.intr & win_any;
    assign eoi     = reg_we_i & (reg_addr_i == 1'(REG_ADDR_CMD))
                     & (reg_wdata_i == DW'(EOI_CMD_CODE));
    assign mask_wr = reg_we_i & (reg_addr_i == 1'(REG_ADDR_MASK));

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_i;
        st_d.irr  = (st_q.irr & ~(ack ? win_onehot : '0)) | rise;
        st_d.isr  = (st_q.isr & ~(eoi ? isr_low : '0)) | (ack ? win_onehot : '0);
        if (mask_wr) st_d.mask = reg_wdata_i[N-1:0];
        if (ack) st_d.vec = VEC_BASE + DW'(win_idx);
        st_d.intr = (st_q.isr == '0) & win_any & ~ack;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.irr  <= '0;
            st_q.isr  <= '0;
            st_q.mask <= '0;
            st_q.prev <= '0;
            st_q.intr <= 1'b0;
            st_q.vec  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_o = st_q.intr;
    assign vec_o = st_q.vec;

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == 1'(REG_ADDR_MASK)) reg_rdata_o[N-1:0] = st_q.mask;
        else if (rd_isr_i)                   reg_rdata_o[N-1:0] = st_q.isr;
        else                                 reg_rdata_o[N-1:0] = st_q.irr;
    end

    // R6: no interrupt raised while a line is in service
    a_r6_no_int_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.isr != '0) |-> !int_o);

    // R7: at most one line is ever in service
    a_r7_isr_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.isr));

    // R5: acknowledge yields a vector inside the line range and a set in-service bit
    a_r5_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (vec_o >= DW'(VEC_BASE)) && (vec_o < DW'(VEC_BASE) + DW'(N))
                && (st_q.isr != '0) && !int_o);

    // R8: a masked line is never the one acknowledged
    a_r8_masked_not_won: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ((win_onehot & st_q.mask) == '0));

    // R4: the granted line is a pending line and is the only grant
    a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ($countones(win_onehot) == 1) && ((win_onehot & st_q.irr) != '0));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_i = '0;
    logic       inta_i = 1'b0;
    logic       int_o;
    logic [7:0] vec_o;
    logic       reg_we_i = 1'b0;
    logic       reg_addr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic       rd_isr_i = 1'b0;
    logic [7:0] reg_rdata_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .inta_i(inta_i),
        .int_o(int_o), .vec_o(vec_o), .reg_we_i(reg_we_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .rd_isr_i(rd_isr_i), .reg_rdata_o(reg_rdata_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic rd(input logic addr, input logic sel, output logic [7:0] v);
        reg_addr_i = addr;
        rd_isr_i = sel;
        #1;
        v = reg_rdata_o;
    endtask

    task automatic wr(input logic addr, input logic [7:0] d);
        reg_we_i = 1'b1;
        reg_addr_i = addr;
        reg_wdata_i = d;
        tick();
        reg_we_i = 1'b0;
    endtask

    task automatic pulse(input int n);
        irq_i[n] = 1'b1;
        tick();
        irq_i[n] = 1'b0;
    endtask

    task automatic acknowledge();
        inta_i = 1'b1;
        tick();
        inta_i = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check("R1 int", int_o, 0);
        rd(0, 0, v); check("R1 irr", v, 0);
        rd(0, 1, v); check("R1 isr", v, 0);
        rd(1, 0, v); check("R1 mask", v, 0);

        // Sweep each line alone
        for (int i = 0; i < N; i++) begin
            pulse(i);
            rd(0, 0, v); check("R2 irr after edge", v, 1 << i);
            check("R3 int not yet", int_o, 0);
            tick();
            check("R3 int raised", int_o, 1);
            acknowledge();
            check("R5 vector", vec_o, 8'h08 + i);
            check("R5 int falls", int_o, 0);
            rd(0, 0, v); check("R5 irr cleared", v, 0);
            rd(0, 1, v); check("R9 isr readback", v, 1 << i);
            wr(0, 8'h20);
            rd(0, 1, v); check("R7 eoi clears", v, 0);
            tick();
            check("R3 idle", int_o, 0);
        end

        // All eight pending: served in priority order
        irq_i = 8'hFF;
        tick();
        irq_i = 8'h00;
        rd(0, 0, v); check("R2 all pending", v, 8'hFF);
        tick();
        for (int i = 0; i < N; i++) begin
            check("R10 int after eoi", int_o, 1);
            acknowledge();
            check("R4 order vector", vec_o, 8'h08 + i);
            rd(0, 0, v); check("R4 remaining", v, (8'hFF << (i + 1)) & 8'hFF);
            wr(0, 8'h20);
            tick();
        end
        check("R4 drained", int_o, 0);

        // Mask line 1
        wr(1, 8'h02);
        rd(1, 0, v); check("R8 mask readback", v, 8'h02);
        pulse(1);
        tick(); tick(); tick();
        check("R8 masked no int", int_o, 0);
        rd(0, 0, v); check("R8 still recorded", v, 8'h02);
        wr(1, 8'h00);
        tick();
        check("R10 unmask dispatch", int_o, 1);
        acknowledge();
        check("R8 vector after unmask", vec_o, 8'h09);

        // Non-preemption: line 1 in service, line 0 arrives
        pulse(0);
        tick(); tick();
        check("R6 no preempt", int_o, 0);
        // Non-EOI command leaves isr
        wr(0, 8'h11);
        rd(0, 1, v); check("R7 non-eoi ignored", v, 8'h02);
        tick();
        check("R7 still blocked", int_o, 0);
        wr(0, 8'h20);
        tick();
        check("R10 resume", int_o, 1);
        acknowledge();
        check("R6 vector after resume", vec_o, 8'h08);
        wr(0, 8'h20);

        // Held line makes one request only
        irq_i[3] = 1'b1;
        tick(); tick();
        check("R2 held raises", int_o, 1);
        acknowledge();
        check("R2 held vector", vec_o, 8'h0B);
        wr(0, 8'h20);
        tick(); tick(); tick();
        check("R2 held no repeat", int_o, 0);
        rd(0, 0, v); check("R2 held irr clear", v, 0);
        irq_i[3] = 1'b0;
        tick();

        // Masked higher line does not win over lower
        wr(1, 8'h01);
        irq_i = 8'h21;
        tick();
        irq_i = 8'h00;
        tick();
        acknowledge();
        check("R8 masked skipped", vec_o, 8'h0D);
        wr(0, 8'h20);
        wr(1, 8'h00);
        tick();
        acknowledge();
        check("R4 then line 0", vec_o, 8'h08);
        wr(0, 8'h20);

        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule